// File: doc/BRIEF.md
# Modifier-Control Write Hazard Detector

This block sits beside the issue stage of an address-generation pipeline and watches one decoded instruction per cycle. When an instruction rewrites the modifier-control register, the new modifier settings are not yet visible to the address arithmetic for a short window. An address-generation access that depends on those settings and arrives inside that window is a spacing violation. The block finds such accesses and either reports them or holds them back.

A small saturating counter records how many cycles have passed since the most recent modifier-control write. Each instruction is classified as a dependent use or not, from its valid bit, its address-generation bit, its address register index and its addressing-mode class. In flag mode a violation raises `hazard_o` for the cycle of the offending instruction. In stall mode `stall_o` is raised instead. The issue stage keeps presenting the same instruction while the bubbles advance the counter, and the instruction is released as soon as the spacing becomes legal.

Top module: `modctl_hazard_guard`

## Requirements
- R1: After reset the elapsed-cycle counter is saturated (window closed), so a dependent use in the first cycles after reset raises neither `hazard_o` nor `stall_o`.
- R2: A dependent use issued in the cycle right after a modifier-control write, or with exactly one slot between them, is a violation. With two or more slots between them it is legal.
- R3: An access through address registers 8 to 15 (`areg_i` >= 8) never raises a hazard or a stall, whatever its mode.
- R4: Mode code 0 (plain indirect, no update) never raises a hazard, even on registers 0 to 7. Mode codes 5 to 7 are reserved and behave the same way.
- R5: On registers 0 to 7, mode codes 1 (post-update), 2 (indexed), 3 (pre-calculated) and 4 (register add, `areg_i` naming the register the add changes) are dependent uses. This holds for any register 0 to 7, not only the one whose modifier field changed.
- R6: Every accepted write, whether a full move or a single-bit set or clear, reloads the counter to zero. Back-to-back writes therefore restart the window.
- R7: Slots with `valid_i` low, and valid slots with `agu_i` low, never raise a hazard or a stall. Every cycle, valid or not, advances the counter.
- R8: With `stall_mode_i` high, a violation drives `stall_o` high and `hazard_o` low. A held instruction stalls for 2 minus the number of elapsed slots and is released in the following cycle.
- R9: With `stall_mode_i` low, `stall_o` stays low and each violating instruction raises `hazard_o` for exactly its own cycle.
- R10: An instruction that both writes modifier control and makes a dependent use is judged against the earlier write. While it is stalled its own write is not accepted, and its write reloads the counter only in the cycle it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_mode_i | input | 1 | 1: hold violators with stall_o, 0: flag them with hazard_o |
| valid_i | input | 1 | Slot carries a real instruction |
| mctl_wr_i | input | 1 | Instruction writes the modifier-control register (move or bit set/clear) |
| agu_i | input | 1 | Instruction performs an address-generation access |
| areg_i | input | 4 | Affected address register index 0..15 |
| amode_i | input | 3 | Mode class: 0 plain, 1 post-update, 2 indexed, 3 pre-calc, 4 register add, 5..7 reserved |
| hazard_o | output | 1 | Violation flagged (flag mode) |
| stall_o | output | 1 | Hold current instruction (stall mode) |

## Verification
Two functions can land in the same cycle: the check of a dependent use, and the counter reload from a write carried by that same instruction. The bench provokes this by issuing a write-plus-use right behind another write, in both modes. In flag mode the instruction must be flagged and must still restart the window. In stall mode it must stall for the full window, and only its release cycle may reload the counter, which a following dependent use then shows by stalling for two more cycles. A seeded random stream mixes these pairs with all register and mode codes and is judged against a bench model of the counter.

// File: rtl/modctl_pkg.sv
package modctl_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POST    = 3'd1,
    AM_INDEX   = 3'd2,
    AM_PRECALC = 3'd3,
    AM_REGADD  = 3'd4
  } amode_e;
endpackage

// File: rtl/modctl_use_classify.sv
module modctl_use_classify
  import modctl_pkg::*;
#(
  parameter int AREG_W   = 4,
  parameter int MOD_REGS = 8
) (
  input  logic              valid_i,
  input  logic              agu_i,
  input  logic [AREG_W-1:0] areg_i,
  input  logic [2:0]        amode_i,
  output logic              dep_use_o
);
  localparam logic [AREG_W-1:0] MOD_LIM = AREG_W'(MOD_REGS);

  amode_e am;
  logic   mode_dep;
  logic   reg_mod;

  assign am      = amode_e'(amode_i);
  assign reg_mod = (areg_i < MOD_LIM);

  always_comb begin
    unique case (am)
      AM_POST, AM_INDEX, AM_PRECALC, AM_REGADD: mode_dep = 1'b1;
      default:                                  mode_dep = 1'b0;
    endcase
  end

  assign dep_use_o = valid_i && agu_i && reg_mod && mode_dep;
endmodule

// File: rtl/modctl_gap_counter.sv
module modctl_gap_counter #(
  parameter int MIN_GAP = 2,
  localparam int CNT_W  = $clog2(MIN_GAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             open_o
);
  localparam logic [CNT_W-1:0] GAP_L = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= GAP_L;
    else if (load_i)         cnt_q <= '0;
    else if (cnt_q < GAP_L)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign open_o = (cnt_q < GAP_L);

  assert_sat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= GAP_L);
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == '0);
  assert_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q < GAP_L) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/modctl_hazard_resolve.sv
module modctl_hazard_resolve (
  input  logic dep_use_i,
  input  logic win_open_i,
  input  logic stall_mode_i,
  output logic hazard_o,
  output logic stall_o
);
  logic viol;

  assign viol     = dep_use_i && win_open_i;
  assign hazard_o = viol && !stall_mode_i;
  assign stall_o  = viol &&  stall_mode_i;
endmodule

// File: rtl/modctl_hazard_guard.sv
module modctl_hazard_guard #(
  parameter int AREG_W   = 4,
  parameter int MOD_REGS = 8,
  parameter int MIN_GAP  = 2,
  localparam int CNT_W   = $clog2(MIN_GAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_mode_i,
  input  logic              valid_i,
  input  logic              mctl_wr_i,
  input  logic              agu_i,
  input  logic [AREG_W-1:0] areg_i,
  input  logic [2:0]        amode_i,
  output logic              hazard_o,
  output logic              stall_o
);
  localparam logic [AREG_W-1:0] MOD_LIM = AREG_W'(MOD_REGS);

  logic             dep_use;
  logic             win_open;
  logic             load;
  logic [CNT_W-1:0] gap_cnt;

  modctl_use_classify #(.AREG_W(AREG_W), .MOD_REGS(MOD_REGS)) u_classify (
    .valid_i  (valid_i),
    .agu_i    (agu_i),
    .areg_i   (areg_i),
    .amode_i  (amode_i),
    .dep_use_o(dep_use)
  );

  // a held write is not accepted until its own release
  assign load = valid_i && mctl_wr_i && !stall_o;

  modctl_gap_counter #(.MIN_GAP(MIN_GAP)) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cnt_o (gap_cnt),
    .open_o(win_open)
  );

  modctl_hazard_resolve u_resolve (
    .dep_use_i   (dep_use),
    .win_open_i  (win_open),
    .stall_mode_i(stall_mode_i),
    .hazard_o    (hazard_o),
    .stall_o     (stall_o)
  );

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hazard_o && stall_o));
  assert_hi_regs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (areg_i >= MOD_LIM) |-> !(hazard_o || stall_o));
  assert_plain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amode_i == 3'd0 || amode_i > 3'd4) |-> !(hazard_o || stall_o));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || !agu_i) |-> !(hazard_o || stall_o));
  assert_flag_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_mode_i |-> !stall_o);
  assert_held_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> gap_cnt != '0);
endmodule

// File: tb/modctl_hazard_guard_bench.sv
module modctl_hazard_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smode = 1'b0, vld = 1'b0, wr = 1'b0, agu = 1'b0;
  logic [3:0] areg = '0;
  logic [2:0] amode = '0;
  logic hz, st;
  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  int m_cnt = 2;
  bit done = 0;

  always #2 clk = ~clk;

  modctl_hazard_guard u_modctl_hazard_guard (
    .clk_i(clk), .rst_ni(rst_n), .stall_mode_i(smode), .valid_i(vld),
    .mctl_wr_i(wr), .agu_i(agu), .areg_i(areg), .amode_i(amode),
    .hazard_o(hz), .stall_o(st)
  );

  function automatic bit f_dep(bit v, bit a, logic [3:0] r, logic [2:0] m);
    return v && a && (r < 4'd8) && (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic bit f_viol(int c, bit v, bit a, logic [3:0] r, logic [2:0] m);
    return f_dep(v, a, r, m) && (c < 2);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one slot: drive at negedge, check, advance model at posedge
  task automatic slot(bit v, bit w, bit a, logic [3:0] r, logic [2:0] m,
                      int eh, int es, string tag);
    bit vi;
    vld = v; wr = w; agu = a; areg = r; amode = m;
    #1;
    vi = f_viol(m_cnt, v, a, r, m);
    if (eh < 0) eh = (vi && !smode) ? 1 : 0;
    if (es < 0) es = (vi && smode) ? 1 : 0;
    chk(hz == eh[0], {tag, " hazard"}, hz, eh);
    chk(st == es[0], {tag, " stall"}, st, es);
    @(posedge clk);
    if (v && w && !(vi && smode)) m_cnt = 0;
    else if (m_cnt < 2) m_cnt++;
    @(negedge clk);
  endtask

  task automatic nop();
    slot(0, 0, 0, 4'd0, 3'd0, 0, 0, "R7 nop");
  endtask

  task automatic wr_only();
    slot(1, 1, 0, 4'd0, 3'd0, 0, 0, "R6 write");
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(hz == 1'b0 && st == 1'b0, "R1 reset outputs", {hz, st}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: dependent uses straight after reset
    slot(1, 0, 1, 4'd0, 3'd1, 0, 0, "R1 first use");
    slot(1, 0, 1, 4'd3, 3'd2, 0, 0, "R1 second use");
    // R2: spacing
    wr_only(); slot(1, 0, 1, 4'd0, 3'd1, 1, 0, "R2 zero gap");
    wr_only(); nop(); slot(1, 0, 1, 4'd0, 3'd1, 1, 0, "R2 one gap");
    wr_only(); nop(); nop(); slot(1, 0, 1, 4'd0, 3'd1, 0, 0, "R2 two gap");
    // R3: high registers
    wr_only(); slot(1, 0, 1, 4'd8, 3'd1, 0, 0, "R3 r8 post");
    wr_only(); slot(1, 0, 1, 4'd15, 3'd4, 0, 0, "R3 r15 add");
    // R4: plain and reserved modes
    wr_only(); slot(1, 0, 1, 4'd0, 3'd0, 0, 0, "R4 plain");
    wr_only(); slot(1, 0, 1, 4'd2, 3'd6, 0, 0, "R4 reserved");
    // R5: each dependent mode, other registers
    wr_only(); slot(1, 0, 1, 4'd5, 3'd1, 1, 0, "R5 r5 post");
    wr_only(); slot(1, 0, 1, 4'd1, 3'd2, 1, 0, "R5 indexed");
    wr_only(); slot(1, 0, 1, 4'd7, 3'd3, 1, 0, "R5 precalc");
    wr_only(); slot(1, 0, 1, 4'd1, 3'd4, 1, 0, "R5 reg add");
    // R6: back-to-back writes restart window
    wr_only(); nop(); wr_only(); nop();
    slot(1, 0, 1, 4'd0, 3'd1, 1, 0, "R6 restart");
    // R7: invalid slots advance, never flag
    wr_only();
    slot(0, 0, 1, 4'd0, 3'd1, 0, 0, "R7 invalid use");
    slot(1, 0, 0, 4'd0, 3'd1, 0, 0, "R7 non-agu");
    slot(1, 0, 1, 4'd0, 3'd1, 0, 0, "R7 expired");
    // R9: flag lasts one cycle
    wr_only(); slot(1, 0, 1, 4'd4, 3'd1, 1, 0, "R9 flag");
    slot(1, 0, 1, 4'd4, 3'd1, 1, 0, "R9 next violator");
    slot(1, 0, 0, 4'd4, 3'd1, 0, 0, "R9 single cycle");
    // R10 flag mode: write+use flagged and restarts window
    wr_only(); nop(); nop();
    wr_only(); slot(1, 1, 1, 4'd2, 3'd1, 1, 0, "R10 flag wr+use");
    slot(1, 0, 1, 4'd2, 3'd1, 1, 0, "R10 flag reload");
    // R8: stall mode
    smode = 1'b1; nop(); nop();
    wr_only();
    slot(1, 0, 1, 4'd2, 3'd1, 0, 1, "R8 stall 1");
    slot(1, 0, 1, 4'd2, 3'd1, 0, 1, "R8 stall 2");
    slot(1, 0, 1, 4'd2, 3'd1, 0, 0, "R8 release");
    wr_only(); nop();
    slot(1, 0, 1, 4'd6, 3'd3, 0, 1, "R8 short stall");
    slot(1, 0, 1, 4'd6, 3'd3, 0, 0, "R8 short release");
    // R10 stall mode
    wr_only();
    slot(1, 1, 1, 4'd0, 3'd2, 0, 1, "R10 held wr 1");
    slot(1, 1, 1, 4'd0, 3'd2, 0, 1, "R10 held wr 2");
    slot(1, 1, 1, 4'd0, 3'd2, 0, 0, "R10 wr release");
    slot(1, 0, 1, 4'd0, 3'd1, 0, 1, "R10 reload seen");
    slot(1, 0, 1, 4'd0, 3'd1, 0, 1, "R10 reload seen 2");
    slot(1, 0, 1, 4'd0, 3'd1, 0, 0, "R10 reload release");
    // random stream, both modes, model-judged
    for (int i = 0; i < 4000; i++) begin
      bit v, w, a, vi;
      logic [3:0] r;
      logic [2:0] m;
      if (i == 2000) smode = 1'b0;
      v = ($urandom % 8) != 0;
      w = ($urandom % 4) == 0;
      a = ($urandom % 4) != 0;
      r = 4'($urandom);
      m = 3'($urandom);
      vi = f_viol(m_cnt, v, a, r, m);
      slot(v, w, a, r, m, -1, -1, "R2/R5 random");
      // held instruction is re-presented until released
      while (vi && smode) begin
        vi = f_viol(m_cnt, v, a, r, m);
        slot(v, w, a, r, m, -1, -1, "R8/R10 random hold");
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule